// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Writes

This block keeps the time of day and the date. A one-second tick from the system advances the seconds. Each rollover carries into the minutes, the hours and then the day. Software reaches the block through a simple register port with three words: a control/status word, a time word and a date word.

Writes to the time or date word do not take effect at once. Each write is held in a pending slot and that word's busy bit in the control word goes high. The held value replaces the running value only after a set number of ticks plus a short settle delay, and the busy bit drops on that same edge. Software polls the busy bits before it writes again.

A build parameter selects how the date is kept. In packed form the date word holds day, month and year fields (year counted from 1970) together with a leap flag that the hardware maintains. In linear form it holds a plain 16-bit day number.

Top module: `cal_clock`

## Requirements
- R1: The time word (offset 0x14) holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. A tick advances the seconds. A field at or above its limit (59 for seconds and minutes, 23 for hours) returns to 0 and carries into the next field. A carry out of 23:59:59 advances the date by one day. Without a tick and without a commit the time word is unchanged.
- R2: In packed mode (LINEAR_DAY=0) the date word (offset 0x10) holds the day in [4:0], the month in [11:8] and the year offset from 1970 in [21:16]. A day step past the month length returns the day to 1 and advances the month. Month 12 returns to 1 and advances the year. Year 63 advances to year 0.
- R3: Date bit 22 is 1 exactly when 1970 plus the year field is a leap year, and February then has 29 days instead of 28. The hardware derives this bit from the year. The value written into bit 22 is ignored.
- R4: A write to the time word sets control bit 8 (control word at offset 0x00). A write to the date word sets control bit 7. Each bit is visible from the cycle after the write. The running value stays unchanged until the commit.
- R5: A pending value is committed SETTLE_CYCLES clock edges (default 2) after the COMMIT_TICKS-th tick (default 1) that follows the write's own edge. The busy bit clears on the same edge. Without further ticks the write stays pending.
- R6: A write to a word whose busy bit is set is ignored, and the first pending value is the one committed. The time word and the date word keep separate busy bits, and a write to one does not block the other.
- R7: Read data is registered and shows, one cycle after the address is presented, the state as it stood on that edge. Control bits other than 8 and 7 read 0. Unmapped addresses read 0. Writes to the control word or to unmapped addresses change nothing.
- R8: When a tick falls on the edge of a commit, the committed word takes the written value unchanged. The other word still takes that tick's step, computed from the values held before the edge.
- R9: In linear mode (LINEAR_DAY=1) date bits [15:0] hold a day count. The count steps on each carry out of 23:59:59 and wraps from 65535 to 0. Bits [31:16] read 0.
- R10: After reset the time reads 00:00:00 and both busy bits are clear. The date reads 1970-01-01 with the leap bit 0 (word 0x00000101) in packed mode, and day 0 in linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A counting tick and a commit of a pending write can fall on the same clock edge. The bench provokes this by issuing a write, then two ticks two cycles apart, so that the second tick lands exactly on the commit edge. In one case the time word is pending while the clock stands at 23:59:59. In the other the date word is pending. The result is judged correct when the committed word shows exactly the written value, with no extra second added. The other word must also have taken the carry implied by the time held just before the edge, so the date advances in the first case, and in the second the time rolls to midnight while the date takes the written value.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_YMD  = 8'h10;
  localparam logic [7:0] ADDR_HMS  = 8'h14;

  localparam int CTRL_HMS_BUSY = 8;
  localparam int CTRL_YMD_BUSY = 7;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } hms_t;

  typedef struct packed {
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } ymd_t;

  function automatic logic [REG_W-1:0] hms_to_word(input hms_t t);
    return {11'd0, t.hour, 2'd0, t.min, 2'd0, t.sec};
  endfunction

  // year field counts from 1970; 1970+y divisible by 4 when y mod 4 == 2
  function automatic logic leap_of(input logic [5:0] y);
    return (y[1:0] == 2'd2);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_commit.sv
module cal_commit
  import cal_pkg::*;
#(
  parameter int COMMIT_TICKS  = 1,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_req,
  input  logic [REG_W-1:0] wr_data,
  output logic             busy,
  output logic             commit,
  output logic [REG_W-1:0] commit_data
);
  localparam int TW = $clog2(COMMIT_TICKS + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic [TW-1:0] ticks_left;
  logic [SW-1:0] settle;

  assign commit = busy && (ticks_left == '0) && (settle <= SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      ticks_left  <= '0;
      settle      <= '0;
      commit_data <= '0;
    end else if (wr_req && !busy) begin
      busy        <= 1'b1;
      ticks_left  <= TW'(COMMIT_TICKS);
      settle      <= '0;
      commit_data <= wr_data;
    end else if (busy) begin
      if (ticks_left != '0) begin
        if (tick) begin
          ticks_left <= ticks_left - TW'(1);
          if (ticks_left == TW'(1)) settle <= SW'(SETTLE_CYCLES);
        end
      end else if (settle <= SW'(1)) begin
        busy <= 1'b0;
      end else begin
        settle <= settle - SW'(1);
      end
    end
  end

  // R4: an accepted write raises busy
  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !busy) |=> busy);
  // R5: busy only drops on a commit edge
  a_r5_busy_drop_on_commit: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(commit));
  a_r5_commit_ends_busy: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);
  // R6: pending value held while busy
  a_r6_pending_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> $stable(commit_data));
endmodule

// File: rtl/cal_hms.sv
module cal_hms
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [REG_W-1:0] load_word,
  output hms_t             now,
  output logic             day_step
);
  hms_t load_val;
  logic sec_last, min_last, hour_last;
  logic unused_load_bits;

  assign load_val.sec  = load_word[5:0];
  assign load_val.min  = load_word[13:8];
  assign load_val.hour = load_word[20:16];
  assign unused_load_bits = ^{load_word[31:21], load_word[15:14], load_word[7:6]};

  assign sec_last  = now.sec  >= 6'd59;
  assign min_last  = now.min  >= 6'd59;
  assign hour_last = now.hour >= 5'd23;
  // carry is taken from the value held before the edge, even on a load
  assign day_step  = tick && sec_last && min_last && hour_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
    end else if (load) begin
      now <= load_val;
    end else if (tick) begin
      if (!sec_last) begin
        now.sec <= now.sec + 6'd1;
      end else begin
        now.sec <= '0;
        if (!min_last) begin
          now.min <= now.min + 6'd1;
        end else begin
          now.min  <= '0;
          now.hour <= hour_last ? 5'd0 : now.hour + 5'd1;
        end
      end
    end
  end

  // R1: time holds between ticks
  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(now));
  // R1: seconds wrap to zero
  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.sec == 6'd59) |=> now.sec == 6'd0);
  // R8: a load wins over a coincident tick
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> now == $past(load_val));
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
#(
  parameter bit LINEAR = 1'b0,
  parameter int LIN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             day_step,
  input  logic             load,
  input  logic [REG_W-1:0] load_word,
  output logic [REG_W-1:0] date_word
);
  generate
    if (LINEAR) begin : g_linear
      logic [LIN_W-1:0] count;
      logic unused_hi;
      assign unused_hi = ^load_word[REG_W-1:LIN_W];

      always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (load)     count <= load_word[LIN_W-1:0];
        else if (day_step) count <= count + LIN_W'(1);
      end

      assign date_word = REG_W'(count);

      // R9: linear day count steps by one and wraps
      a_r9_linear_step: assert property (@(posedge clk) disable iff (rst)
        (day_step && !load) |=> count == $past(count) + LIN_W'(1));
    end else begin : g_packed
      ymd_t       cur;
      logic       leap;
      logic [4:0] mlen;
      ymd_t       wr_val;
      logic       unused_hi;

      assign wr_val.day  = load_word[4:0];
      assign wr_val.mon  = load_word[11:8];
      assign wr_val.year = load_word[21:16];
      assign unused_hi   = ^{load_word[31:22], load_word[15:12], load_word[7:5]};
      assign mlen        = month_days(cur.mon, leap);

      always_ff @(posedge clk) begin
        if (rst) begin
          cur.day  <= 5'd1;
          cur.mon  <= 4'd1;
          cur.year <= 6'd0;
          leap     <= 1'b0;
        end else if (load) begin
          cur  <= wr_val;
          leap <= leap_of(wr_val.year);
        end else if (day_step) begin
          if (cur.day < mlen) begin
            cur.day <= cur.day + 5'd1;
          end else begin
            cur.day <= 5'd1;
            if (cur.mon < 4'd12) begin
              cur.mon <= cur.mon + 4'd1;
            end else begin
              cur.mon  <= 4'd1;
              cur.year <= cur.year + 6'd1;
              leap     <= leap_of(cur.year + 6'd1);
            end
          end
        end
      end

      assign date_word = {9'd0, leap, cur.year, 4'd0, cur.mon, 3'd0, cur.day};

      // R2: year boundary
      a_r2_year_carry: assert property (@(posedge clk) disable iff (rst)
        (day_step && !load && cur.mon == 4'd12 && cur.day == 5'd31) |=>
          (cur.day == 5'd1 && cur.mon == 4'd1 && cur.year == $past(cur.year) + 6'd1));
      // R2: date holds without a day step
      a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!day_step && !load) |=> $stable(date_word));
      // R3: leap February reaches day 29
      a_r3_feb29: assert property (@(posedge clk) disable iff (rst)
        (day_step && !load && leap && cur.mon == 4'd2 && cur.day == 5'd28) |=> cur.day == 5'd29);
    end
  endgenerate
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int COMMIT_TICKS  = 1,
  parameter int SETTLE_CYCLES = 2,
  parameter bit LINEAR_DAY    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_YMD  = ADDR_W'(ADDR_YMD);
  localparam logic [ADDR_W-1:0] A_HMS  = ADDR_W'(ADDR_HMS);
  localparam int N_REGS  = 2;
  localparam int IDX_HMS = 0;
  localparam int IDX_YMD = 1;

  logic [N_REGS-1:0] hit, busy, commit;
  logic [REG_W-1:0]  cdata [N_REGS];
  hms_t              hms_now;
  logic              day_step;
  logic [REG_W-1:0]  date_word;
  logic [REG_W-1:0]  ctrl_word;

  assign hit[IDX_HMS] = reg_wr && (reg_addr == A_HMS);
  assign hit[IDX_YMD] = reg_wr && (reg_addr == A_YMD);

  for (genvar g = 0; g < N_REGS; g++) begin : g_slot
    cal_commit #(
      .COMMIT_TICKS (COMMIT_TICKS),
      .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_commit (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick_1hz),
      .wr_req     (hit[g]),
      .wr_data    (reg_wdata),
      .busy       (busy[g]),
      .commit     (commit[g]),
      .commit_data(cdata[g])
    );
  end

  cal_hms u_hms (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1hz),
    .load     (commit[IDX_HMS]),
    .load_word(cdata[IDX_HMS]),
    .now      (hms_now),
    .day_step (day_step)
  );

  cal_date #(.LINEAR(LINEAR_DAY)) u_date (
    .clk      (clk),
    .rst      (rst),
    .day_step (day_step),
    .load     (commit[IDX_YMD]),
    .load_word(cdata[IDX_YMD]),
    .date_word(date_word)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_HMS_BUSY] = busy[IDX_HMS];
    ctrl_word[CTRL_YMD_BUSY] = busy[IDX_YMD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_word;
        A_YMD:   reg_rdata <= date_word;
        A_HMS:   reg_rdata <= hms_to_word(hms_now);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7: unmapped addresses read zero one cycle later
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != A_CTRL && reg_addr != A_YMD && reg_addr != A_HMS) |=> reg_rdata == '0);
endmodule

// File: tb/test_cal_clock.sv
module test_cal_clock;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] AC = 8'h00, AY = 8'h10, AH = 8'h14;

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_p = 1'b0, wr_l = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_p, rd_l;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock #(.LINEAR_DAY(1'b0)) i_cal_clock (
    .clk(clk), .rst(rst), .tick_1hz(tick), .reg_addr(addr),
    .reg_wr(wr_p), .reg_wdata(wdata), .reg_rdata(rd_p));

  cal_clock #(.LINEAR_DAY(1'b1)) i_cal_clock_lin (
    .clk(clk), .rst(rst), .tick_1hz(tick), .reg_addr(addr),
    .reg_wr(wr_l), .reg_wdata(wdata), .reg_rdata(rd_l));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] hms_w(input int h, input int m, input int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic bit is_leap(input int y);
    int full;
    full = 1970 + y;
    return ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
  endfunction

  function automatic logic [31:0] ymd_w(input int y, input int m, input int d);
    return (32'(is_leap(y)) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return is_leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic wr_reg(input bit lin, input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (lin) wr_l = 1'b1; else wr_p = 1'b1;
    @(negedge clk);
    wr_p = 1'b0; wr_l = 1'b0;
  endtask

  task automatic tick_once();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    addr = a;
    @(negedge clk);
  endtask

  task automatic commit_wr(input bit lin, input logic [7:0] a, input logic [31:0] d);
    wr_reg(lin, a, d);
    tick_once();
    repeat (2) @(negedge clk);
  endtask

  task automatic day_step(input bit lin);
    commit_wr(lin, AH, hms_w(23, 59, 59));
    tick_once();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int y, m, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(AC); check("R10 ctrl", rd_p, 32'h0);
    rd(AH); check("R10 hms", rd_p, 32'h0);
    rd(AY); check("R10 ymd packed", rd_p, 32'h0000_0101);
    check("R10 ymd linear", rd_l, 32'h0);

    // R7 unmapped reads and ignored writes
    rd(8'h04); check("R7 unmapped", rd_p, 32'h0);
    wr_reg(1'b0, AC, 32'hFFFF_FFFF);
    rd(AC); check("R7 ctrl write ignored", rd_p, 32'h0);
    wr_reg(1'b0, 8'h08, 32'h0000_0123);
    rd(AC); check("R7 unmapped write no busy", rd_p, 32'h0);
    rd(AH); check("R7 unmapped write no hms change", rd_p, 32'h0);

    // R4 busy set, value held; R5 exact commit edge
    wr_reg(1'b0, AH, hms_w(5, 6, 7));
    rd(AC); check("R4 hms busy bit8", rd_p, 32'h0000_0100);
    rd(AH); check("R4 hms unchanged before commit", rd_p, 32'h0);
    repeat (5) @(negedge clk);
    rd(AC); check("R5 no commit without tick", rd_p, 32'h0000_0100);
    tick_once();
    rd(AC); check("R5 busy one edge after tick", rd_p, 32'h0000_0100);
    rd(AC); check("R5 busy until settle edge", rd_p, 32'h0000_0100);
    rd(AC); check("R5 busy cleared on commit edge", rd_p, 32'h0);
    rd(AH); check("R5 committed hms", rd_p, hms_w(5, 6, 7));

    // R6 write while busy ignored; slots independent
    wr_reg(1'b0, AH, hms_w(1, 2, 3));
    wr_reg(1'b0, AH, hms_w(4, 4, 4));
    wr_reg(1'b0, AY, ymd_w(1, 2, 3));
    rd(AC); check("R6 both busy bits", rd_p, 32'h0000_0180);
    tick_once();
    repeat (2) @(negedge clk);
    rd(AH); check("R6 first hms kept", rd_p, hms_w(1, 2, 3));
    rd(AY); check("R4 ymd committed", rd_p, ymd_w(1, 2, 3));

    // R1 time sweep across hour and day boundary
    commit_wr(1'b0, AY, ymd_w(0, 1, 1));
    commit_wr(1'b0, AH, hms_w(22, 0, 0));
    for (int i = 1; i <= 7260; i++) begin
      int t;
      t = (22 * 3600 + i) % 86400;
      tick_once();
      rd(AH);
      check("R1 time sweep", rd_p, hms_w(t / 3600, (t / 60) % 60, t % 60));
    end
    rd(AY); check("R1 midnight carry into date", rd_p, ymd_w(0, 1, 2));

    // R2/R3 date sweep over nine years
    commit_wr(1'b0, AY, ymd_w(0, 1, 1));
    y = 0; m = 1; d = 1;
    for (int k = 0; k < 3290; k++) begin
      day_step(1'b0);
      d++;
      if (d > dim(m, y)) begin
        d = 1; m++;
        if (m > 12) begin m = 1; y = (y + 1) % 64; end
      end
      rd(AY); check("R2 R3 date sweep", rd_p, ymd_w(y, m, d));
    end

    // R3 leap bit derived by hardware
    commit_wr(1'b0, AY, (32'd30 << 16) | (32'd2 << 8) | 32'd28);
    rd(AY); check("R3 leap bit for 2000", rd_p, ymd_w(30, 2, 28));
    day_step(1'b0);
    rd(AY); check("R3 Feb 29 2000", rd_p, ymd_w(30, 2, 29));
    commit_wr(1'b0, AY, (32'd1 << 22) | (32'd1 << 16) | (32'd2 << 8) | 32'd28);
    rd(AY); check("R3 written leap bit ignored", rd_p, ymd_w(1, 2, 28));
    day_step(1'b0);
    rd(AY); check("R3 non-leap Feb to Mar", rd_p, ymd_w(1, 3, 1));

    // R2 last year wraps to first
    commit_wr(1'b0, AY, ymd_w(63, 12, 31));
    day_step(1'b0);
    rd(AY); check("R2 year 63 wrap", rd_p, ymd_w(0, 1, 1));
    rd(AH); check("R1 midnight time", rd_p, 32'h0);

    // R8 tick on the commit edge, time pending
    commit_wr(1'b0, AY, ymd_w(5, 6, 30));
    commit_wr(1'b0, AH, hms_w(23, 59, 58));
    wr_reg(1'b0, AH, hms_w(10, 0, 0));
    tick_once();
    @(negedge clk);
    tick_once();
    rd(AH); check("R8 committed hms exact", rd_p, hms_w(10, 0, 0));
    rd(AY); check("R8 date took carry", rd_p, ymd_w(5, 7, 1));

    // R8 tick on the commit edge, date pending
    commit_wr(1'b0, AH, hms_w(23, 59, 58));
    wr_reg(1'b0, AY, ymd_w(7, 3, 15));
    tick_once();
    @(negedge clk);
    tick_once();
    rd(AY); check("R8 committed ymd exact", rd_p, ymd_w(7, 3, 15));
    rd(AH); check("R8 hms rolled", rd_p, 32'h0);

    // R9 linear day mode
    commit_wr(1'b1, AY, 32'd100);
    rd(AY); check("R9 linear load", rd_l, 32'd100);
    day_step(1'b1);
    rd(AY); check("R9 linear step", rd_l, 32'd101);
    commit_wr(1'b1, AY, 32'hFFFF_FFFF);
    rd(AY); check("R9 linear upper bits zero", rd_l, 32'h0000_FFFF);
    day_step(1'b1);
    rd(AY); check("R9 linear wrap", rd_l, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule